// File: doc/BRIEF.md
# Line Alarm Status and Interrupt Hub

This block gathers the alarm conditions of a multi-channel line interface (seven channels by default) and turns them into live status bits and a single active-high interrupt. Each channel supplies a loss-of-signal flag from its receiver and a transmit clock. The master clock is supervised as well. All logic runs on a free-running oscillator clock `clk`. A watched clock counts as lost when `clk` sees no rising edge on it for a set number of cycles.

A clock-loss alarm stays asserted for a minimum hold time, even if the clock comes back sooner. A new loss detection restarts that hold time. A lost master clock forces every channel's loss-of-signal status high. While a channel's transmit clock is lost, that channel's transmit line data is forced to zero.

Masks are active high and act only on the interrupt. The status outputs always show the true alarm state.

Top module: `line_alarm_hub`

## Requirements
- R1: After reset, `los_stat`, `txc_stat`, `mclk_stat` and `irq` are all 0.
- R2: A watched clock (a bit of `tx_clk_in`, or `mclk_in`) is declared lost once LOSS_CYC consecutive `clk` cycles pass without a rising edge on it. A clock with a rising edge at least every 4 `clk` cycles raises no alarm.
- R3: Once a clock-loss alarm asserts, it stays high for at least HOLD_CYC `clk` cycles, even if the clock resumes right away. It clears after the hold time if the clock is running.
- R4: A fresh loss detection while the hold time is running reloads the hold time to its full value.
- R5: While the master-clock alarm (`mclk_stat`) is high, every bit of `los_stat` is 1 one cycle later.
- R6: `los_stat[i]` follows `sig_loss_in[i]` with a one-cycle delay when the master clock is present.
- R7: `irq` is 1 when at least one of these holds: (a) a `los_stat[i]` is set with both `mask_los[i]` and `mask_ch[i]` at 0; (b) a `txc_stat[i]` is set with both `mask_txc[i]` and `mask_ch[i]` at 0; (c) `mclk_stat` is set with `mask_mclk` at 0. `irq` is registered, so it follows the status by one cycle. `mask_ch` has no effect on the master-clock term.
- R8: The mask inputs have no effect on `los_stat`, `txc_stat` or `mclk_stat`.
- R9: `tx_pos_out[i]` and `tx_neg_out[i]` are 0 while `txc_stat[i]` is 1. Otherwise they equal `tx_pos_in[i]` and `tx_neg_in[i]`.
- R10: A loss on one channel's transmit clock sets only that channel's bit of `txc_stat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_in | input | 1 | Master clock to be watched |
| tx_clk_in | input | NUM_CH | Transmit clock of each channel, to be watched |
| sig_loss_in | input | NUM_CH | Raw loss-of-signal flag of each channel's receiver |
| tx_pos_in | input | NUM_CH | Positive-rail transmit data |
| tx_neg_in | input | NUM_CH | Negative-rail transmit data |
| mask_los | input | NUM_CH | Interrupt mask for loss of signal, per channel, 1 = masked |
| mask_txc | input | NUM_CH | Interrupt mask for transmit-clock loss, per channel, 1 = masked |
| mask_ch | input | NUM_CH | Channel-wide interrupt mask covering both channel alarms, 1 = masked |
| mask_mclk | input | 1 | Interrupt mask for master-clock loss, 1 = masked |
| los_stat | output | NUM_CH | Loss-of-signal status, including master-clock loss |
| txc_stat | output | NUM_CH | Transmit-clock-loss status |
| mclk_stat | output | 1 | Master-clock-loss status |
| tx_pos_out | output | NUM_CH | Positive-rail transmit data after gating |
| tx_neg_out | output | NUM_CH | Negative-rail transmit data after gating |
| irq | output | 1 | Active-high combined interrupt |

## Verification
The bench builds the block with seven channels and LOSS_CYC = 8, and shortens HOLD_CYC from its default of 4128 to 40. With a 40-cycle hold, a short dropout can be followed by a check that the alarm is still up at mid-hold and down once the hold has run out. A second dropout near the end of the first hold then shows the hold being reloaded. The watched clocks toggle every two `clk` cycles, which keeps the running case well inside the loss window.

// File: rtl/line_alarm_pkg.sv
package line_alarm_pkg;
  // Counter width able to hold values 0..max_val.
  function automatic int cnt_bits(input int max_val);
    if (max_val < 2) return 1;
    return $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/line_clk_watch.sv
module line_clk_watch #(
  parameter int LOSS_CYC    = 8,
  parameter int HOLD_CYC    = 4128,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_clk,
  output logic alarm
);
  localparam int GW = line_alarm_pkg::cnt_bits(LOSS_CYC);
  localparam int HW = line_alarm_pkg::cnt_bits(HOLD_CYC);
  localparam logic [GW-1:0] GAP_MAX = GW'(LOSS_CYC);
  localparam logic [HW-1:0] HOLD_V  = HW'(HOLD_CYC);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [SYNC_STAGES:0]   sync_ext;
  logic                   prev_q, sampled, rise;
  logic [GW-1:0]          gap_q, gap_d;
  logic [HW-1:0]          hold_q, hold_d;
  logic                   alarm_q, alarm_d;
  logic                   lost_q, lost_d, new_loss;

  // Synchroniser and edge detect.
  assign sync_ext = {sync_q, mon_clk};
  assign sync_d   = sync_ext[SYNC_STAGES-1:0];
  assign sampled  = sync_q[SYNC_STAGES-1];
  assign rise     = sampled & ~prev_q;

  // Next-state logic: gap counter saturates at the loss limit; hold
  // counter reloads on each entry into the lost state.
  always_comb begin
    if (rise)                 gap_d = '0;
    else if (gap_q == GAP_MAX) gap_d = gap_q;
    else                       gap_d = gap_q + GW'(1);
    lost_q   = (gap_q == GAP_MAX);
    lost_d   = (gap_d == GAP_MAX);
    new_loss = lost_d & ~lost_q;
    if (new_loss)            hold_d = HOLD_V;
    else if (hold_q != '0)   hold_d = hold_q - HW'(1);
    else                     hold_d = hold_q;
    alarm_d = lost_d | (hold_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      gap_q   <= '0;
      hold_q  <= '0;
      alarm_q <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      prev_q  <= sampled;
      gap_q   <= gap_d;
      hold_q  <= hold_d;
      alarm_q <= alarm_d;
    end
  end

  assign alarm = alarm_q;

  // Checker state: length of the current alarm run (saturating).
  logic [HW-1:0] hi_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hi_q <= '0;
    else if (!alarm_q)       hi_q <= '0;
    else if (hi_q != HOLD_V) hi_q <= hi_q + HW'(1);
  end

  // R3: an alarm run never ends before the hold time has elapsed.
  a_r3_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_q && !alarm_d) |-> (hi_q >= HOLD_V - HW'(1)));

  // R2: a saturated gap counter always comes with a raised alarm.
  a_r2_gap_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q == GAP_MAX) |-> alarm_q);

  // R4: a new detection leaves a full hold time loaded.
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    new_loss |=> (hold_q == HOLD_V));
endmodule

// File: rtl/line_irq_merge.sv
module line_irq_merge #(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] los,
  input  logic [NUM_CH-1:0] txc,
  input  logic              mclk_lost,
  input  logic [NUM_CH-1:0] mask_los,
  input  logic [NUM_CH-1:0] mask_txc,
  input  logic [NUM_CH-1:0] mask_ch,
  input  logic              mask_mclk,
  output logic              irq
);
  logic [NUM_CH-1:0] ch_req;
  logic              irq_d, irq_q;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
      assign ch_req[gi] = ~mask_ch[gi] &
                          ((los[gi] & ~mask_los[gi]) | (txc[gi] & ~mask_txc[gi]));
    end
  endgenerate

  always_comb irq_d = (|ch_req) | (mclk_lost & ~mask_mclk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R7: with every channel and the master-clock mask set, no interrupt.
  a_r7_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((&mask_ch) && mask_mclk) |=> !irq);

  // R7: an unmasked master-clock loss always raises the interrupt.
  a_r7_mclk_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (mclk_lost && !mask_mclk) |=> irq);
endmodule

// File: rtl/line_alarm_hub.sv
module line_alarm_hub #(
  parameter int NUM_CH      = 7,
  parameter int LOSS_CYC    = 8,
  parameter int HOLD_CYC    = 4128,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclk_in,
  input  logic [NUM_CH-1:0] tx_clk_in,
  input  logic [NUM_CH-1:0] sig_loss_in,
  input  logic [NUM_CH-1:0] tx_pos_in,
  input  logic [NUM_CH-1:0] tx_neg_in,
  input  logic [NUM_CH-1:0] mask_los,
  input  logic [NUM_CH-1:0] mask_txc,
  input  logic [NUM_CH-1:0] mask_ch,
  input  logic              mask_mclk,
  output logic [NUM_CH-1:0] los_stat,
  output logic [NUM_CH-1:0] txc_stat,
  output logic              mclk_stat,
  output logic [NUM_CH-1:0] tx_pos_out,
  output logic [NUM_CH-1:0] tx_neg_out,
  output logic              irq
);
  logic [NUM_CH-1:0] txc_alarm;
  logic              mclk_alarm;
  logic [NUM_CH-1:0] los_d, los_q;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_txw
      line_clk_watch #(
        .LOSS_CYC(LOSS_CYC), .HOLD_CYC(HOLD_CYC), .SYNC_STAGES(SYNC_STAGES)
      ) u_txw (
        .clk(clk), .rst_n(rst_n), .mon_clk(tx_clk_in[gi]), .alarm(txc_alarm[gi])
      );
      // Transmit rails are held at zero while the channel clock is lost.
      assign tx_pos_out[gi] = tx_pos_in[gi] & ~txc_alarm[gi];
      assign tx_neg_out[gi] = tx_neg_in[gi] & ~txc_alarm[gi];
    end
  endgenerate

  line_clk_watch #(
    .LOSS_CYC(LOSS_CYC), .HOLD_CYC(HOLD_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) u_mclkw (
    .clk(clk), .rst_n(rst_n), .mon_clk(mclk_in), .alarm(mclk_alarm)
  );

  // Master-clock loss is folded into every loss-of-signal bit.
  always_comb los_d = sig_loss_in | {NUM_CH{mclk_alarm}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) los_q <= '0;
    else        los_q <= los_d;
  end

  line_irq_merge #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .los(los_q), .txc(txc_alarm), .mclk_lost(mclk_alarm),
    .mask_los(mask_los), .mask_txc(mask_txc), .mask_ch(mask_ch),
    .mask_mclk(mask_mclk), .irq(irq)
  );

  assign los_stat  = los_q;
  assign txc_stat  = txc_alarm;
  assign mclk_stat = mclk_alarm;

  // R5: master-clock loss drives every loss-of-signal bit high.
  a_r5_mclk_all_los: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_alarm |=> (&los_stat));

  // R9: no channel drives line data while its clock alarm is up.
  a_r9_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_pos_out & txc_stat) == '0) && ((tx_neg_out & txc_stat) == '0));

  // R6: without master-clock loss, status follows the raw input.
  a_r6_los_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_alarm |=> (los_stat == $past(sig_loss_in)));
endmodule

// File: tb/line_alarm_hub_bench.sv
module line_alarm_hub_bench;
  localparam int CLK_P = 10;
  localparam int N     = 7;
  localparam int LOSS  = 8;
  localparam int HOLD  = 40;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   ph = 2'd0;
  logic [N-1:0] tx_run;
  logic         m_run;
  logic         mclk_in;
  logic [N-1:0] tx_clk_in, sig_loss_in, tx_pos_in, tx_neg_in;
  logic [N-1:0] mask_los, mask_txc, mask_ch;
  logic         mask_mclk;
  logic [N-1:0] los_stat, txc_stat, tx_pos_out, tx_neg_out;
  logic         mclk_stat, irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(negedge clk) ph <= ph + 2'd1;
  assign tx_clk_in = tx_run & {N{ph[1]}};
  assign mclk_in   = m_run & ph[1];

  line_alarm_hub #(.NUM_CH(N), .LOSS_CYC(LOSS), .HOLD_CYC(HOLD)) u_line_alarm_hub (
    .clk(clk), .rst_n(rst_n), .mclk_in(mclk_in), .tx_clk_in(tx_clk_in),
    .sig_loss_in(sig_loss_in), .tx_pos_in(tx_pos_in), .tx_neg_in(tx_neg_in),
    .mask_los(mask_los), .mask_txc(mask_txc), .mask_ch(mask_ch),
    .mask_mclk(mask_mclk), .los_stat(los_stat), .txc_stat(txc_stat),
    .mclk_stat(mclk_stat), .tx_pos_out(tx_pos_out), .tx_neg_out(tx_neg_out),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; tx_run = '1; m_run = 1'b1;
    sig_loss_in = '0; tx_pos_in = '1; tx_neg_in = '1;
    mask_los = '1; mask_txc = '1; mask_ch = '1; mask_mclk = 1'b1;
    step(3);
    chk("R1 los_stat in reset", 32'(los_stat), 0);
    chk("R1 irq in reset", 32'(irq), 0);
    rst_n = 1'b1;
    step(20);
    chk("R1 los_stat", 32'(los_stat), 0);
    chk("R1 mclk_stat", 32'(mclk_stat), 0);
    chk("R2 running clocks no alarm", 32'(txc_stat), 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_los_follow;
    sig_loss_in = 7'b0000101;
    step(3);
    chk("R6 los follows input", 32'(los_stat), 32'h05);
    chk("R8 masked irq low, status visible", 32'(irq), 0);
  endtask

  task automatic t_masks;
    mask_los[0] = 1'b0;
    step(3);
    chk("R7 channel mask still gates los", 32'(irq), 0);
    mask_ch[0] = 1'b0;
    step(3);
    chk("R7 unmasked los raises irq", 32'(irq), 1);
    mask_los[0] = 1'b1;
    step(3);
    chk("R7 los mask alone gates", 32'(irq), 0);
    chk("R8 masks leave status", 32'(los_stat), 32'h05);
    mask_ch[0] = 1'b1;
    sig_loss_in = '0;
    tx_run[3] = 1'b0;
    step(14);
    chk("R2 lost tx clock detected", 32'(txc_stat), 32'h08);
    chk("R10 only channel 3 flagged", 32'(txc_stat & ~7'h08), 0);
    chk("R9 tx_pos gated", 32'(tx_pos_out), 32'h77);
    chk("R9 tx_neg gated", 32'(tx_neg_out), 32'h77);
    mask_txc[3] = 1'b0;
    step(3);
    chk("R7 channel mask gates txc", 32'(irq), 0);
    mask_ch[3] = 1'b0;
    step(3);
    chk("R7 unmasked txc raises irq", 32'(irq), 1);
    mask_txc[3] = 1'b1;
    step(3);
    chk("R7 txc mask alone gates", 32'(irq), 0);
    mask_ch[3] = 1'b1;
    tx_run[3] = 1'b1;
    step(70);
    chk("R3 alarm clears after hold", 32'(txc_stat), 0);
    chk("R9 tx_pos passes through", 32'(tx_pos_out), 32'h7f);
  endtask

  task automatic t_hold;
    tx_run[1] = 1'b0;
    step(14);
    chk("R2 dropout detected", 32'(txc_stat[1]), 1);
    tx_run[1] = 1'b1;
    step(20);
    chk("R3 alarm held after clock returns", 32'(txc_stat[1]), 1);
    step(36);
    chk("R3 alarm released", 32'(txc_stat[1]), 0);
  endtask

  task automatic t_restart;
    tx_run[5] = 1'b0;
    step(14);
    tx_run[5] = 1'b1;
    step(16);
    tx_run[5] = 1'b0;
    step(14);
    tx_run[5] = 1'b1;
    step(20);
    chk("R4 second loss reloads hold", 32'(txc_stat[5]), 1);
    step(36);
    chk("R4 reloaded hold ends", 32'(txc_stat[5]), 0);
  endtask

  task automatic t_mclk;
    sig_loss_in = '0;
    m_run = 1'b0;
    step(14);
    chk("R2 master clock loss", 32'(mclk_stat), 1);
    chk("R5 all los bits forced", 32'(los_stat), 32'h7f);
    chk("R7 masked mclk irq low", 32'(irq), 0);
    mask_mclk = 1'b0;
    step(3);
    chk("R7 unmasked mclk raises irq despite channel masks", 32'(irq), 1);
    mask_mclk = 1'b1;
    m_run = 1'b1;
    step(70);
    chk("R5 los released after mclk returns", 32'(los_stat), 0);
    chk("R3 mclk alarm released", 32'(mclk_stat), 0);
    chk("R7 irq low at end", 32'(irq), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_los_follow();
    t_masks();
    t_hold();
    t_restart();
    t_mclk();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule